// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block keeps the status state of a serial flash device and rules on every write request that the command front-end hands it. It holds the write-enable latch, a two-bit protection level and a protect-enable bit. It combines them with the active-low write-protect pin. For program, sector erase, chip erase and status-register write it either starts a self-timed cycle or refuses the request. The cycle time is counted down in clock cycles and drives the busy bit.

The front-end presents one decoded command per cycle with `cmdValid`, along with its byte address and, for a status write, its data byte. One cycle later the unit pulses `cmdAccept` or `cmdRefuse` for write-type commands. With an accepted erase it also presents the sector mask the array must clear. The status byte is always visible on `statusByte` so that a status-read path can shift it out. The nonvolatile bits are modelled as registers that reset to zero.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset the status byte is 0x00. A write-type command (program code 3, sector erase 4, chip erase 5, status write 6) given while the write-enable latch is clear is refused and does not set busy.
- R2: Command code 1 sets the write-enable latch (status bit 1). Command code 2 clears it, whatever the level of `wpN`.
- R3: The write-enable latch returns to 0 when an accepted write cycle ends and also when a write-type command is refused.
- R4: After an accepted command, status bit 0 is 1 for exactly PROG_CYC, SECT_CYC, CHIP_CYC or SR_CYC cycles (program, sector erase, chip erase, status write). It starts in the cycle after the command and is 0 otherwise.
- R5: The sector is given by the two top address bits. Protection level 0 locks nothing, 1 locks sector 3, 2 locks sectors 2 and 3, and 3 locks all four. A program or sector erase aimed at a locked sector is refused.
- R6: When the protect-enable bit is 1 and `wpN` is low, a status write is refused and the protect-enable bit stays 1.
- R7: When the protect-enable bit is 0, the level of `wpN` has no effect on a status write.
- R8: `eraseMask` (bit n for sector n) is valid with `cmdAccept`. A sector erase gives the one-hot mask of the addressed sector. A chip erase gives all unlocked sectors, and a chip erase with every sector locked is refused. A program gives 0.
- R9: While busy, every command is ignored. No accept or refuse pulse appears, and the latch, the protection bits and the remaining busy time are unchanged.
- R10: The status byte is {protect-enable, 3'b000, level[1:0], latch, busy}. A status write takes the level from data bits 3:2 and the protect-enable bit from data bit 7, ignores the other bits, and shows the new values when its cycle ends.
- R11: `cmdAccept` and `cmdRefuse` are single-cycle pulses in the cycle after the command. A write-type command gives exactly one of them, and codes 0, 1 and 2 give neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | A decoded command is present this cycle |
| cmdOp | input | 3 | Command code: 0 none, 1 set latch, 2 clear latch, 3 program, 4 sector erase, 5 chip erase, 6 status write |
| cmdAddr | input | ADDR_W | Byte address of program or sector erase |
| cmdData | input | 8 | Data byte of a status write |
| wpN | input | 1 | Write-protect pin, active low |
| statusByte | output | 8 | Current status byte |
| cmdAccept | output | 1 | Write command started its timed cycle |
| cmdRefuse | output | 1 | Write command refused |
| eraseMask | output | 4 | Sectors to erase, valid with cmdAccept |

## Verification
The main sweep crosses all four protection levels with every sector for program and sector erase, and adds a chip erase at each level. This separates an off-by-one in the lock boundary from a wrong sector decode or a wrong erase mask. It also measures every cycle length. Status writes are tried with the pin high and low and with protect-enable set and clear, which isolates the hardware lock from the latch check. Commands injected during a busy cycle show whether the unit truly ignores them and whether the remaining cycle time is shortened.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  localparam int NUM_SECTORS = 4;
  localparam int SEC_W       = 2;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WREN   = 3'd1,
    OP_WRDI   = 3'd2,
    OP_PROG   = 3'd3,
    OP_SERASE = 3'd4,
    OP_CERASE = 3'd5,
    OP_WRSR   = 3'd6
  } flashOp_e;

  // Strobes from control to the status datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic stageSr;
    logic commitSr;
  } srStrobe_t;

endpackage

// File: rtl/flash_wp_timer.sv
module flash_wp_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (load)      cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  // R9: a new cycle is never started on top of a running one
  p_load_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    load |-> !busy);

  // R4: a cycle is loaded with a non-zero length
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    load |=> busy);

endmodule

// File: rtl/flash_wp_dp.sv
module flash_wp_dp
  import flash_wp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  srStrobe_t              strobe,
  input  logic [1:0]             newLevel,
  input  logic                   newEnable,
  output logic                   wel,
  output logic [1:0]             level,
  output logic                   protEn,
  output logic [NUM_SECTORS-1:0] lockMask
);

  logic [1:0] stagedLevel;
  logic       stagedEnable;
  int unsigned lockedCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wel <= 1'b0;
    else if (strobe.clrWel)  wel <= 1'b0;
    else if (strobe.setWel)  wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedLevel  <= '0;
      stagedEnable <= 1'b0;
    end else if (strobe.stageSr) begin
      stagedLevel  <= newLevel;
      stagedEnable <= newEnable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= '0;
      protEn <= 1'b0;
    end else if (strobe.commitSr) begin
      level  <= stagedLevel;
      protEn <= stagedEnable;
    end
  end

  always_comb begin
    case (level)
      2'd0:    lockedCount = 0;
      2'd1:    lockedCount = NUM_SECTORS / 4;
      2'd2:    lockedCount = NUM_SECTORS / 2;
      default: lockedCount = NUM_SECTORS;
    endcase
  end

  // Protection grows downward from the top sector
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_lock
    assign lockMask[s] = (s >= (NUM_SECTORS - lockedCount));
  end

  // R5: the top sector is locked whenever any protection is active
  p_top_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (level != 2'd0) |-> lockMask[NUM_SECTORS-1]);

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int PROG_CYC = 6,
  parameter int SECT_CYC = 10,
  parameter int CHIP_CYC = 14,
  parameter int SR_CYC   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  flashOp_e               cmdOp,
  input  logic [SEC_W-1:0]       secIdx,
  input  logic                   wpN,
  input  logic                   wel,
  input  logic                   protEn,
  input  logic [NUM_SECTORS-1:0] lockMask,
  input  logic                   busy,
  input  logic                   done,
  output srStrobe_t              strobe,
  output logic                   tmrLoad,
  output logic [CNT_W-1:0]       tmrVal,
  output logic                   cmdAccept,
  output logic                   cmdRefuse,
  output logic [NUM_SECTORS-1:0] eraseMask
);

  logic                   take;
  logic                   isWrite;
  logic                   allowed;
  logic                   hwLock;
  logic [NUM_SECTORS-1:0] secOneHot;
  logic [NUM_SECTORS-1:0] maskNext;

  assign take      = cmdValid && !busy;
  assign hwLock    = protEn && !wpN;
  assign secOneHot = NUM_SECTORS'(1) << secIdx;

  always_comb begin
    isWrite  = 1'b0;
    allowed  = 1'b0;
    tmrVal   = '0;
    maskNext = '0;
    case (cmdOp)
      OP_PROG: begin
        isWrite = 1'b1;
        allowed = wel && !lockMask[secIdx];
        tmrVal  = CNT_W'(PROG_CYC);
      end
      OP_SERASE: begin
        isWrite  = 1'b1;
        allowed  = wel && !lockMask[secIdx];
        tmrVal   = CNT_W'(SECT_CYC);
        maskNext = secOneHot;
      end
      OP_CERASE: begin
        isWrite  = 1'b1;
        allowed  = wel && (~lockMask != '0);
        tmrVal   = CNT_W'(CHIP_CYC);
        maskNext = ~lockMask;
      end
      OP_WRSR: begin
        isWrite = 1'b1;
        allowed = wel && !hwLock;
        tmrVal  = CNT_W'(SR_CYC);
      end
      default: ;
    endcase
  end

  assign tmrLoad = take && isWrite && allowed;

  always_comb begin
    strobe          = '0;
    strobe.setWel   = take && (cmdOp == OP_WREN);
    strobe.clrWel   = done
                   || (take && (cmdOp == OP_WRDI))
                   || (take && isWrite && !allowed);
    strobe.stageSr  = tmrLoad && (cmdOp == OP_WRSR);
    strobe.commitSr = done;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAccept <= 1'b0;
      cmdRefuse <= 1'b0;
      eraseMask <= '0;
    end else begin
      cmdAccept <= tmrLoad;
      cmdRefuse <= take && isWrite && !allowed;
      eraseMask <= tmrLoad ? maskNext : '0;
    end
  end

  // R1: nothing starts unless the latch was set
  p_accept_needs_wel_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |-> $past(wel));

  // R1: a refusal never leaves the unit busy
  p_refuse_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdRefuse |-> !busy);

  // R4: an accepted command is always followed by a busy cycle
  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |-> busy);

  // R8: an erase mask never touches a locked sector
  p_mask_unlocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |-> ((eraseMask & lockMask) == '0));

  // R9: commands seen while busy produce no response
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !(cmdAccept || cmdRefuse));

  // R11: the two responses are exclusive
  p_one_response_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdAccept, cmdRefuse}));

endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int PROG_CYC = 6,
  parameter int SECT_CYC = 10,
  parameter int CHIP_CYC = 14,
  parameter int SR_CYC   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              wpN,
  output logic [7:0]        statusByte,
  output logic              cmdAccept,
  output logic              cmdRefuse,
  output logic [3:0]        eraseMask
);

  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B   = (CHIP_CYC > SR_CYC) ? CHIP_CYC : SR_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  srStrobe_t              strobe;
  logic                   wel;
  logic [1:0]             level;
  logic                   protEn;
  logic [NUM_SECTORS-1:0] lockMask;
  logic                   busy;
  logic                   done;
  logic                   tmrLoad;
  logic [CNT_W-1:0]       tmrVal;
  logic [SEC_W-1:0]       secIdx;
  logic                   unusedInputs;

  assign secIdx       = cmdAddr[ADDR_W-1 -: SEC_W];
  assign unusedInputs = ^{cmdAddr[ADDR_W-SEC_W-1:0], cmdData[6:4], cmdData[1:0]};

  flash_wp_ctrl #(
    .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .CHIP_CYC(CHIP_CYC), .SR_CYC(SR_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(flashOp_e'(cmdOp)), .secIdx(secIdx),
    .wpN(wpN), .wel(wel), .protEn(protEn), .lockMask(lockMask),
    .busy(busy), .done(done),
    .strobe(strobe), .tmrLoad(tmrLoad), .tmrVal(tmrVal),
    .cmdAccept(cmdAccept), .cmdRefuse(cmdRefuse), .eraseMask(eraseMask)
  );

  flash_wp_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .newLevel(cmdData[3:2]), .newEnable(cmdData[7]),
    .wel(wel), .level(level), .protEn(protEn), .lockMask(lockMask)
  );

  flash_wp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rstN(rstN), .load(tmrLoad), .loadVal(tmrVal),
    .busy(busy), .done(done)
  );

  assign statusByte = {protEn, 3'b000, level, wel, busy};

  // R3: the latch is gone once a cycle has finished
  p_wel_clear_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !wel);

  // R6: protect-enable cannot be dropped while the pin holds it
  p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (protEn && !wpN && !busy) |=> protEn);

  // R10: protection bits only move at the end of a cycle
  p_level_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(level));

endmodule

// File: tb/flash_wp_unit_bench.sv
module flash_wp_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 17;
  localparam int PROG_CYC = 6;
  localparam int SECT_CYC = 10;
  localparam int CHIP_CYC = 14;
  localparam int SR_CYC   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [2:0]        cmdOp = 3'd0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0]        cmdData = '0;
  logic              wpN = 1'b1;
  logic [7:0]        statusByte;
  logic              cmdAccept;
  logic              cmdRefuse;
  logic [3:0]        eraseMask;

  int total = 0;
  int fails = 0;
  logic       gotAcc, gotRef;
  logic [3:0] gotMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wp_unit #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .CHIP_CYC(CHIP_CYC), .SR_CYC(SR_CYC)
  ) u_flash_wp_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wpN(wpN),
    .statusByte(statusByte), .cmdAccept(cmdAccept),
    .cmdRefuse(cmdRefuse), .eraseMask(eraseMask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one command for one edge; sample the registered response after it
  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
    gotAcc = cmdAccept; gotRef = cmdRefuse; gotMask = eraseMask;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (statusByte[0]) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setLevel(input logic [7:0] d);
    int n;
    issue(3'd1, '0, 8'h00);
    issue(3'd6, '0, d);
    waitIdle(n);
  endtask

  function automatic bit isLocked(input int lv, input int s);
    int cnt;
    cnt = (lv == 0) ? 0 : (lv == 1) ? 1 : (lv == 2) ? 2 : 4;
    return s >= 4 - cnt;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset status", statusByte, 8'h00);
    chk("R11 reset no pulse", {cmdAccept, cmdRefuse}, 2'b00);

    // R1: write without latch
    issue(3'd3, '0, 8'h00);
    chk("R1 program without latch refused", {gotAcc, gotRef}, 2'b01);
    chk("R1 no busy after refusal", statusByte, 8'h00);

    // R11: latch commands give no pulse
    issue(3'd1, '0, 8'h00);
    chk("R2 set latch", statusByte, 8'h02);
    chk("R11 no pulse on latch set", {gotAcc, gotRef}, 2'b00);
    wpN = 1'b0;
    issue(3'd2, '0, 8'h00);
    chk("R2 clear latch with pin low", statusByte, 8'h00);
    chk("R11 no pulse on latch clear", {gotAcc, gotRef}, 2'b00);
    wpN = 1'b1;

    // R10/R4: status write with reserved bits set
    issue(3'd1, '0, 8'h00);
    issue(3'd6, '0, 8'hFF);
    chk("R11 status write accepted", {gotAcc, gotRef}, 2'b10);
    chk("R10 old bits held during cycle", statusByte, 8'h03);
    waitIdle(n);
    chk("R4 status write length", n, SR_CYC);
    chk("R10 new status layout", statusByte, 8'h8C);

    // R6: hardware lock
    wpN = 1'b0;
    issue(3'd1, '0, 8'h00);
    chk("R6 latch settable under lock", statusByte, 8'h8E);
    issue(3'd6, '0, 8'h00);
    chk("R6 status write refused", {gotAcc, gotRef}, 2'b01);
    chk("R3 R6 enable kept and latch cleared", statusByte, 8'h8C);

    // Pin released: status write allowed again
    wpN = 1'b1;
    issue(3'd1, '0, 8'h00);
    issue(3'd6, '0, 8'h00);
    chk("R6 accepted with pin high", {gotAcc, gotRef}, 2'b10);
    waitIdle(n);
    chk("R10 status cleared", statusByte, 8'h00);

    // R7: enable clear, pin low ignored
    wpN = 1'b0;
    issue(3'd1, '0, 8'h00);
    issue(3'd6, '0, 8'h04);
    chk("R7 pin ignored when enable clear", {gotAcc, gotRef}, 2'b10);
    waitIdle(n);
    chk("R7 level written", statusByte, 8'h04);
    wpN = 1'b1;

    // R5/R8/R4/R3 sweep
    for (int lv = 0; lv < 4; lv++) begin
      setLevel(8'(lv << 2));
      chk("R10 level programmed", statusByte, 32'(lv << 2));
      for (int op = 3; op <= 4; op++) begin
        for (int s = 0; s < 4; s++) begin
          bit ok;
          ok = !isLocked(lv, s);
          issue(3'd1, '0, 8'h00);
          issue(3'(op), {2'(s), 15'h0123}, 8'h00);
          chk("R5 response", {gotAcc, gotRef}, ok ? 2'b10 : 2'b01);
          chk("R8 mask", gotMask, (ok && op == 4) ? 32'(1 << s) : 32'd0);
          waitIdle(n);
          chk("R4 cycle length", n, ok ? ((op == 3) ? PROG_CYC : SECT_CYC) : 0);
          chk("R3 latch cleared", statusByte, 32'(lv << 2));
        end
      end
      begin
        logic [3:0] expMask;
        expMask = '0;
        for (int s = 0; s < 4; s++) expMask[s] = !isLocked(lv, s);
        issue(3'd1, '0, 8'h00);
        issue(3'd5, '0, 8'h00);
        chk("R8 chip erase response", {gotAcc, gotRef}, (expMask != 0) ? 2'b10 : 2'b01);
        chk("R8 chip erase mask", gotMask, (expMask != 0) ? expMask : 4'h0);
        waitIdle(n);
        chk("R4 chip erase length", n, (expMask != 0) ? CHIP_CYC : 0);
        chk("R3 latch after chip erase", statusByte, 32'(lv << 2));
      end
    end

    // R9: commands during busy
    setLevel(8'h00);
    issue(3'd1, '0, 8'h00);
    issue(3'd3, '0, 8'h00);
    chk("R9 program started", {gotAcc, gotRef}, 2'b10);
    issue(3'd2, '0, 8'h00);
    chk("R9 latch kept despite clear while busy", statusByte, 8'h03);
    issue(3'd6, '0, 8'h0C);
    chk("R9 no pulse while busy", {gotAcc, gotRef}, 2'b00);
    waitIdle(n);
    chk("R9 remaining time unchanged", n, PROG_CYC - 4);
    chk("R9 level unchanged", statusByte, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule